// File: doc/BRIEF.md
# I2C Target with General-Call Filtering

This block is the target (slave) side of a two-wire I2C bus. It takes the raw SCL and SDA levels from an open-drain bus, passes them through a short synchronizer running on a fast system clock, and finds START, repeated START and STOP conditions from edges of the synchronized lines. It never drives SDA high. It drives a single output-enable, and when that enable is set the bus line is pulled low.

After a START the block shifts in a 7-bit address and a direction bit, MSB first. It then decides whether to acknowledge in the ninth SCL cycle. It answers its programmable own address and, when enabled, the general-call address on writes. It never answers reserved addresses. It also refuses any packet while the local side signals busy. Write bytes that it accepts go out on a one-cycle byte strobe. On a read, the block fetches each byte from a local source with a one-cycle request strobe and shifts it onto the bus. It stops sending when the controller answers a byte with NACK.

Top module: `i2cgc_target`

## Requirements
- R1: SDA falling while SCL is high starts address reception. SDA rising while SCL is high returns the block to idle with SDA released, and `stop_pulse` is high for exactly one clock per STOP.
- R2: An address packet is 7 address bits (MSB first) followed by a direction bit (1 = read, 0 = write). If the address equals `own_addr`, the block pulls SDA low (`sda_oe` = 1) during the ninth SCL cycle.
- R3: If the address matches nothing, the block leaves SDA released for that cycle and for every later cycle up to the next START or STOP.
- R4: Address 0000000 with a write bit is acknowledged only when `gc_en` = 1. The data bytes that follow are then delivered with `rx_gc` = 1. Own-address bytes carry `rx_gc` = 0.
- R5: Address 0000000 with a read bit is never acknowledged. No data bit is driven afterwards and `tx_req` does not pulse.
- R6: Addresses whose top four bits are 1111 are never acknowledged, even when `own_addr` holds such a value.
- R7: If `busy` = 1 at the start of an acknowledge slot, the address or data packet is refused (SDA stays released). A refused data byte produces no `rx_valid`, and the block releases the bus until the next START or STOP.
- R8: Each accepted write byte (MSB first on the bus) is acknowledged and appears on `rx_data` with a one-clock `rx_valid` pulse.
- R9: On an accepted read, `tx_data` is taken in the clock where `tx_req` pulses, at the end of the acknowledge cycle. Its bits are then driven MSB first, with `sda_oe` equal to the inverse of each bit.
- R10: A controller ACK (SDA low in the ninth cycle) after a transmitted byte fetches the next byte. A controller NACK makes the block release SDA and ignore the bus until the next START or STOP.
- R11: A repeated START in the middle of any packet discards the partial byte and restarts address reception.
- R12: `sda_oe` changes only while SCL is low, except when it is released at a START or STOP.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Raw SCL level from the bus |
| sda_i | input | 1 | Raw SDA level from the bus |
| sda_oe | output | 1 | 1 pulls SDA low, 0 releases it |
| own_addr | input | ADDR_W | Programmed own address |
| gc_en | input | 1 | Enables acknowledge of general-call writes |
| busy | input | 1 | Local side cannot serve; refuse packets |
| rx_data | output | DATA_W | Received write byte |
| rx_valid | output | 1 | One-clock strobe for `rx_data` |
| rx_gc | output | 1 | Byte arrived under a general call |
| tx_data | input | DATA_W | Byte to transmit on reads |
| tx_req | output | 1 | One-clock strobe: `tx_data` taken |
| stop_pulse | output | 1 | One-clock strobe on STOP |

## Verification
The byte-complete strobe and the busy refusal are both decided on the same falling SCL edge, the one that opens the data acknowledge slot. The bench raises `busy` just before that edge, after the address has already been acknowledged. It then expects a NACK on the bus and no `rx_valid` pulse. A repeated START is also sent while a data byte is half shifted in, so that condition detection and bit shifting compete. The bench judges this by the next byte that is delivered: only the byte sent after the restart may appear.

// File: rtl/i2cgc_pkg.sv
`timescale 1ns/1ps
package i2cgc_pkg;
   typedef enum logic [2:0] {
      ST_IDLE,
      ST_ADDR,
      ST_RX,
      ST_TX,
      ST_WAIT
   } tgt_state_t;
endpackage

// File: rtl/i2cgc_sync.sv
`timescale 1ns/1ps
// Multi-stage level synchronizer; resets to the idle bus level.
module i2cgc_sync #(
   parameter int   STAGES  = 2,
   parameter logic RST_VAL = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   if (STAGES < 2) begin : g_bad_stages
      $error("i2cgc_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] chain;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= {STAGES{RST_VAL}};
      else        chain <= {chain[STAGES-2:0], d};
   end

   assign q = chain[STAGES-1];
endmodule

// File: rtl/i2cgc_cond.sv
`timescale 1ns/1ps
// Edge and bus-condition detector on synchronized lines.
module i2cgc_cond (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_s,
   input  logic sda_s,
   output logic scl_rise,
   output logic scl_fall,
   output logic start_det,
   output logic stop_det
);
   logic scl_q, sda_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_q <= 1'b1;
         sda_q <= 1'b1;
      end else begin
         scl_q <= scl_s;
         sda_q <= sda_s;
      end
   end

   assign scl_rise  =  scl_s & ~scl_q;
   assign scl_fall  = ~scl_s &  scl_q;
   assign start_det =  scl_s &  scl_q &  sda_q & ~sda_s;
   assign stop_det  =  scl_s &  scl_q & ~sda_q &  sda_s;

   // Both conditions need SCL high across two samples, so they exclude SCL edges.
   p_cond_excl_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (start_det || stop_det) |-> !(scl_rise || scl_fall));
endmodule

// File: rtl/i2cgc_addr_match.sv
`timescale 1ns/1ps
// Address acknowledge decision: own address, optional general call,
// reserved group refusal and busy refusal.
module i2cgc_addr_match #(
   parameter int ADDR_W     = 7,
   parameter bit GC_SUPPORT = 1'b1
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic              rw,
   input  logic [ADDR_W-1:0] own_addr,
   input  logic              gc_en,
   input  logic              busy,
   output logic              ack,
   output logic              is_gc
);
   localparam int RSV_W = 4;

   if (ADDR_W < RSV_W) begin : g_bad_width
      $error("i2cgc_addr_match: ADDR_W too small");
   end

   logic reserved, hit_own, gc_ok;

   assign reserved = &addr[ADDR_W-1 -: RSV_W];
   assign hit_own  = (addr == own_addr) && !reserved && (addr != '0);

   if (GC_SUPPORT) begin : g_gc
      assign is_gc = (addr == '0);
      assign gc_ok = is_gc && gc_en && !rw;
   end else begin : g_no_gc
      assign is_gc = 1'b0;
      assign gc_ok = 1'b0;
   end

   assign ack = !busy && (hit_own || gc_ok);
endmodule

// File: rtl/i2cgc_target.sv
`timescale 1ns/1ps
module i2cgc_target #(
   parameter int ADDR_W      = 7,
   parameter int DATA_W      = 8,
   parameter int SYNC_STAGES = 2,
   parameter bit GC_SUPPORT  = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              scl_i,
   input  logic              sda_i,
   output logic              sda_oe,
   input  logic [ADDR_W-1:0] own_addr,
   input  logic              gc_en,
   input  logic              busy,
   output logic [DATA_W-1:0] rx_data,
   output logic              rx_valid,
   output logic              rx_gc,
   input  logic [DATA_W-1:0] tx_data,
   output logic              tx_req,
   output logic              stop_pulse
);
   import i2cgc_pkg::*;

   localparam int              CNT_W   = $clog2(DATA_W + 2);
   localparam logic [CNT_W-1:0] CNT_ACK = CNT_W'(DATA_W);
   localparam logic [CNT_W-1:0] CNT_END = CNT_W'(DATA_W + 1);

   if (DATA_W != ADDR_W + 1) begin : g_bad_pkt
      $error("i2cgc_target: DATA_W must equal ADDR_W + 1");
   end

   logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
   logic m_ack, m_gc;

   tgt_state_t        st;
   logic [CNT_W-1:0]  cnt;
   logic [DATA_W-1:0] sh;
   logic              rw_q, gc_q, ack_q;

   i2cgc_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_scl_sync (
      .clk(clk), .rst_n(rst_n), .d(scl_i), .q(scl_s));
   i2cgc_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sda_sync (
      .clk(clk), .rst_n(rst_n), .d(sda_i), .q(sda_s));

   i2cgc_cond u_cond (
      .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .sda_s(sda_s),
      .scl_rise(scl_rise), .scl_fall(scl_fall),
      .start_det(start_det), .stop_det(stop_det));

   i2cgc_addr_match #(.ADDR_W(ADDR_W), .GC_SUPPORT(GC_SUPPORT)) u_match (
      .addr(sh[DATA_W-1:1]), .rw(sh[0]), .own_addr(own_addr),
      .gc_en(gc_en), .busy(busy), .ack(m_ack), .is_gc(m_gc));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st         <= ST_IDLE;
         cnt        <= '0;
         sh         <= '0;
         rw_q       <= 1'b0;
         gc_q       <= 1'b0;
         ack_q      <= 1'b0;
         sda_oe     <= 1'b0;
         rx_data    <= '0;
         rx_valid   <= 1'b0;
         rx_gc      <= 1'b0;
         tx_req     <= 1'b0;
         stop_pulse <= 1'b0;
      end else begin
         rx_valid   <= 1'b0;
         tx_req     <= 1'b0;
         stop_pulse <= 1'b0;
         if (stop_det) begin
            st         <= ST_IDLE;
            cnt        <= '0;
            sda_oe     <= 1'b0;
            stop_pulse <= 1'b1;
         end else if (start_det) begin
            st     <= ST_ADDR;
            cnt    <= '0;
            sda_oe <= 1'b0;
         end else if (st == ST_ADDR || st == ST_RX || st == ST_TX) begin
            if (scl_rise) begin
               if (st != ST_TX && cnt < CNT_ACK) sh <= {sh[DATA_W-2:0], sda_s};
               if (st == ST_TX && cnt == CNT_ACK) ack_q <= ~sda_s;
               if (cnt <= CNT_ACK) cnt <= cnt + 1'b1;
            end else if (scl_fall) begin
               if (cnt == CNT_ACK) begin
                  // Acknowledge slot opens.
                  case (st)
                     ST_ADDR: begin
                        ack_q  <= m_ack;
                        rw_q   <= sh[0];
                        gc_q   <= m_gc;
                        sda_oe <= m_ack;
                     end
                     ST_RX: begin
                        ack_q  <= !busy;
                        sda_oe <= !busy;
                        if (!busy) begin
                           rx_valid <= 1'b1;
                           rx_data  <= sh;
                           rx_gc    <= gc_q;
                        end
                     end
                     default: sda_oe <= 1'b0;
                  endcase
               end else if (cnt == CNT_END) begin
                  // Acknowledge slot closes.
                  cnt    <= '0;
                  sda_oe <= 1'b0;
                  if (!ack_q) begin
                     st <= ST_WAIT;
                  end else if (st == ST_TX || (st == ST_ADDR && rw_q)) begin
                     st     <= ST_TX;
                     sh     <= tx_data;
                     sda_oe <= ~tx_data[DATA_W-1];
                     tx_req <= 1'b1;
                  end else begin
                     st <= ST_RX;
                  end
               end else if (st == ST_TX && cnt != '0) begin
                  sh     <= {sh[DATA_W-2:0], 1'b0};
                  sda_oe <= ~sh[DATA_W-2];
               end
            end
         end
      end
   end

   // R12: the pull-down changes only with SCL low, or on release at a condition.
   p_oe_scl_low_r12: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(sda_oe) |-> (!$past(scl_s) || $past(start_det) || $past(stop_det)));

   // R1: a STOP strobe always comes with the bus released.
   p_stop_release_r1: assert property (@(posedge clk) disable iff (!rst_n)
      stop_pulse |-> !sda_oe);

   // R3: idle and waiting states never hold SDA.
   p_wait_released_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_WAIT || st == ST_IDLE) |-> !sda_oe);

   // R5: a general call never leads into transmission.
   p_gc_no_tx_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_TX) |-> !gc_q);

   // R6: a reserved-group address is never acknowledged.
   p_rsvd_nack_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_ADDR && scl_fall && cnt == CNT_ACK && (&sh[DATA_W-1 -: 4]))
      |=> !sda_oe);

   // R7: busy at the data acknowledge slot refuses the byte.
   p_busy_refuse_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_RX && scl_fall && cnt == CNT_ACK && busy) |=> (!sda_oe && !rx_valid));

   // R8: a delivered byte never coincides with a STOP strobe.
   p_rx_not_stop_r8: assert property (@(posedge clk) disable iff (!rst_n)
      rx_valid |-> !stop_pulse);
endmodule

// File: tb/i2cgc_target_tb.sv
`timescale 1ns/1ps
module i2cgc_target_tb;
   localparam int Q = 10;   // quarter SCL period in clocks
   localparam int H = 20;   // half SCL period in clocks

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       scl_m = 1'b1;
   logic       sda_m = 1'b1;
   logic       sda_oe;
   logic [6:0] own_addr = 7'h3A;
   logic       gc_en = 1'b0;
   logic       busy = 1'b0;
   logic [7:0] rx_data;
   logic       rx_valid, rx_gc, tx_req, stop_pulse;
   logic [7:0] tx_data;
   wire        sda_bus = sda_m & ~sda_oe;

   int n_checks = 0, n_fail = 0;
   int rx_n = 0, stop_n = 0, txr_n = 0, oe_viol = 0;
   logic [7:0] rx_buf [0:15];
   logic       gc_buf [0:15];
   logic [7:0] tx_bytes [0:3];
   logic       prev_oe = 1'b0;

   always #2 clk = ~clk;   // 250 MHz

   i2cgc_target u_dut (
      .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_bus),
      .sda_oe(sda_oe), .own_addr(own_addr), .gc_en(gc_en), .busy(busy),
      .rx_data(rx_data), .rx_valid(rx_valid), .rx_gc(rx_gc),
      .tx_data(tx_data), .tx_req(tx_req), .stop_pulse(stop_pulse));

   assign tx_data = tx_bytes[txr_n[1:0]];

   always @(negedge clk) begin
      if (rx_valid && rx_n < 16) begin
         rx_buf[rx_n] = rx_data;
         gc_buf[rx_n] = rx_gc;
      end
      if (rx_valid) rx_n++;
      if (stop_pulse) stop_n++;
      if (tx_req) txr_n++;
      if (sda_oe !== prev_oe && scl_m) oe_viol++;
      prev_oe = sda_oe;
   end

   task automatic check(input bit ok, input string req, input int act, input int exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic w(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic bus_start();
      sda_m = 1'b1; w(Q);
      scl_m = 1'b1; w(H);
      sda_m = 1'b0; w(H);
      scl_m = 1'b0; w(Q);
   endtask

   task automatic bus_stop();
      sda_m = 1'b0; w(Q);
      scl_m = 1'b1; w(H);
      sda_m = 1'b1; w(H);
   endtask

   task automatic put_bit(input bit b);
      sda_m = b;    w(Q);
      scl_m = 1'b1; w(H);
      scl_m = 1'b0; w(Q);
   endtask

   task automatic get_bit(output bit b);
      sda_m = 1'b1; w(Q);
      scl_m = 1'b1; w(H/2);
      b = sda_bus;  w(H/2);
      scl_m = 1'b0; w(Q);
   endtask

   task automatic wr_byte(input logic [7:0] v, output bit ack);
      bit a;
      for (int i = 7; i >= 0; i--) put_bit(v[i]);
      get_bit(a);
      ack = !a;
   endtask

   task automatic rd_byte(output logic [7:0] v, input bit mack);
      bit b;
      for (int i = 7; i >= 0; i--) begin
         get_bit(b);
         v[i] = b;
      end
      put_bit(!mack);
      sda_m = 1'b1;
   endtask

   task automatic t_reset();
      check(sda_oe == 1'b0, "R1 reset sda_oe", sda_oe, 0);
      check(rx_valid == 1'b0 && tx_req == 1'b0 && stop_pulse == 1'b0,
            "R1 reset strobes", {rx_valid, tx_req, stop_pulse}, 0);
   endtask

   task automatic t_write();
      bit a; int n0 = rx_n; int s0 = stop_n;
      bus_start();
      wr_byte({7'h3A, 1'b0}, a); check(a, "R2 own address ack", a, 1);
      wr_byte(8'hA5, a);         check(a, "R8 data ack 1", a, 1);
      wr_byte(8'h3C, a);         check(a, "R8 data ack 2", a, 1);
      bus_stop();
      check(rx_n == n0 + 2, "R8 byte count", rx_n - n0, 2);
      check(rx_buf[n0] == 8'hA5 && gc_buf[n0] == 1'b0, "R8 byte 1", rx_buf[n0], 8'hA5);
      check(rx_buf[n0+1] == 8'h3C, "R8 byte 2", rx_buf[n0+1], 8'h3C);
      check(stop_n == s0 + 1, "R1 stop pulse", stop_n - s0, 1);
      check(sda_oe == 1'b0, "R1 released after stop", sda_oe, 0);
   endtask

   task automatic t_miss();
      bit a; int n0 = rx_n;
      bus_start();
      wr_byte({7'h15, 1'b0}, a); check(!a, "R3 foreign address nack", a, 0);
      wr_byte(8'h77, a);         check(!a, "R3 later byte nack", a, 0);
      bus_stop();
      check(rx_n == n0, "R3 no delivery", rx_n - n0, 0);
   endtask

   task automatic t_gc();
      bit a; int n0 = rx_n;
      gc_en = 1'b1;
      bus_start();
      wr_byte(8'h00, a); check(a, "R4 general call ack", a, 1);
      wr_byte(8'hC3, a); check(a, "R4 general call data ack", a, 1);
      bus_stop();
      check(rx_n == n0 + 1 && rx_buf[n0] == 8'hC3, "R4 general call data", rx_buf[n0], 8'hC3);
      check(gc_buf[n0] == 1'b1, "R4 rx_gc flag", gc_buf[n0], 1);
      gc_en = 1'b0;
      bus_start();
      wr_byte(8'h00, a); check(!a, "R4 general call disabled nack", a, 0);
      bus_stop();
   endtask

   task automatic t_gc_read();
      bit a; logic [7:0] v; int t0 = txr_n;
      gc_en = 1'b1;
      bus_start();
      wr_byte(8'h01, a); check(!a, "R5 general call read nack", a, 0);
      rd_byte(v, 1'b0);  check(v == 8'hFF, "R5 no data driven", v, 8'hFF);
      bus_stop();
      check(txr_n == t0, "R5 no tx_req", txr_n - t0, 0);
      gc_en = 1'b0;
   endtask

   task automatic t_reserved();
      bit a;
      own_addr = 7'h7B;
      bus_start();
      wr_byte({7'h7B, 1'b0}, a); check(!a, "R6 reserved address nack", a, 0);
      bus_stop();
      own_addr = 7'h3A;
   endtask

   task automatic t_busy();
      bit a; int n0 = rx_n;
      busy = 1'b1;
      bus_start();
      wr_byte({7'h3A, 1'b0}, a); check(!a, "R7 busy address nack", a, 0);
      bus_stop();
      busy = 1'b0;
      bus_start();
      wr_byte({7'h3A, 1'b0}, a); check(a, "R7 address ack when free", a, 1);
      busy = 1'b1;
      wr_byte(8'h11, a);         check(!a, "R7 busy data nack", a, 0);
      bus_stop();
      busy = 1'b0;
      check(rx_n == n0, "R7 refused byte not delivered", rx_n - n0, 0);
   endtask

   task automatic t_read();
      bit a; logic [7:0] v; int t0 = txr_n;
      bus_start();
      wr_byte({7'h3A, 1'b1}, a); check(a, "R9 read address ack", a, 1);
      rd_byte(v, 1'b1);          check(v == 8'h96, "R9 first byte", v, 8'h96);
      rd_byte(v, 1'b0);          check(v == 8'h3B, "R10 byte after ack", v, 8'h3B);
      rd_byte(v, 1'b0);          check(v == 8'hFF, "R10 released after nack", v, 8'hFF);
      bus_stop();
      check(txr_n == t0 + 2, "R9 tx_req count", txr_n - t0, 2);
   endtask

   task automatic t_restart();
      bit a; int n0 = rx_n;
      bus_start();
      wr_byte({7'h3A, 1'b0}, a); check(a, "R11 first address ack", a, 1);
      put_bit(1'b1); put_bit(1'b0); put_bit(1'b1); put_bit(1'b0);
      bus_start();
      wr_byte({7'h3A, 1'b0}, a); check(a, "R11 address after restart ack", a, 1);
      wr_byte(8'h5A, a);         check(a, "R11 data ack", a, 1);
      bus_stop();
      check(rx_n == n0 + 1 && rx_buf[n0] == 8'h5A, "R11 only new byte", rx_buf[n0], 8'h5A);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

   initial begin
      tx_bytes[0] = 8'h96; tx_bytes[1] = 8'h3B;
      tx_bytes[2] = 8'h00; tx_bytes[3] = 8'h00;
      w(5); rst_n = 1'b1; w(5);
      t_reset();
      t_write();
      t_miss();
      t_gc();
      t_gc_read();
      t_reserved();
      t_busy();
      t_read();
      t_restart();
      check(oe_viol == 0, "R12 sda_oe changes with SCL low", oe_viol, 0);
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end
endmodule